// File: doc/BRIEF.md
# Free-Running Power-Management Timer

This block is a wide free-running up-counter for system timekeeping that stays alive when other timers are halted in low-power states. It counts pulses of an externally supplied tick enable (nominally 3.579545 MHz, three times the legacy interval-timer rate). It has no reload or compare register: after the all-ones value it returns to zero and keeps counting. Software may read the count at any moment.

The block has no terminal-count interrupt. It flags an event each time the top bit of the counter changes value, in either direction. For a 24-bit counter that is once every 2^23 ticks, about every 2.34 s at the nominal rate. The event sets a sticky status bit, which software clears with a one-cycle clear strobe. The interrupt line is that status bit gated by an enable. A separate run input qualifies counting. It is held active in the low-power states where the counter must keep going.

Top module: `freerun_pm_timer`

## Requirements
- R1: While reset is asserted (synchronous, active low), `count` becomes 0 and `sts` becomes 0 at the next clock edge, so `irq` is 0.
- R2: On each clock edge where `tick_en` and `run_en` are both 1, `count` increases by exactly one.
- R3: On a clock edge where `tick_en` is 0 or `run_en` is 0, `count` keeps its value.
- R4: An advancing edge taken at the all-ones count makes `count` zero. No other value is ever loaded.
- R5: `sts` becomes 1 on the edge where bit CNT_W-1 of `count` changes. This covers both the rise at count 2^(CNT_W-1) and the fall at the wrap to zero.
- R6: A 1 on `sts_clr` clears `sts` at the next edge. If a top-bit change happens on that same edge, `sts` is 1 afterwards.
- R7: When there is no clear and no top-bit change, `sts` keeps its value.
- R8: `irq` equals `sts` AND `irq_en`, combinationally and with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Count pulse, one clock wide per tick |
| run_en | input | 1 | Counting allowed; held 1 in low-power states |
| irq_en | input | 1 | Interrupt enable |
| sts_clr | input | 1 | Clears the sticky status bit |
| count | output | CNT_W | Current counter value |
| irq | output | 1 | Interrupt request, status AND enable |
| sts | output | 1 | Sticky top-bit-change status |

## Verification
The bench builds the timer with CNT_W = 6 instead of the default 24. At that width the top bit rises after 32 ticks and falls at the wrap after 64. Both flip directions and the all-ones-to-zero wrap are therefore reachable within a few hundred cycles. A clear strobe can also be placed on exactly the edge of a flip. The counter logic and the flip detection do not depend on the width, so the same paths are exercised as at 24 bits.

// File: rtl/pm_timer_pkg.sv
// Package: shared constants for the free-running power-management timer.
// Assumes nothing beyond a width of at least two bits.
package pm_timer_pkg;
    localparam int unsigned PMT_DEF_WIDTH = 24;
    localparam int unsigned PMT_MIN_WIDTH = 2;
endpackage

// File: rtl/pmt_counter.sv
// Module: pmt_counter
// Free-running up-counter that wraps with no reload. Also reports, on the
// same cycle as the advancing edge, that this edge will change the top bit.
// Assumes CNT_W >= 2 and a synchronous active-low reset.
module pmt_counter #(
    parameter int unsigned CNT_W = pm_timer_pkg::PMT_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run_en,
    output logic [CNT_W-1:0] cnt,
    output logic             top_flip
);
    localparam int unsigned     LOW_W   = CNT_W - 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             adv;
    logic [CNT_W-1:0] cnt_q;

    // Advance only when a tick arrives while counting is allowed.
    assign adv = tick_en & run_en;

    // Count register: clear on reset, step by one on advance, wrap naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= cnt_q + 1'b1;
    end

    // The top bit changes when every lower bit is one and an advance occurs.
    assign top_flip = adv & (&cnt_q[LOW_W-1:0]);
    assign cnt      = cnt_q;

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && run_en) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_en && run_en) |=> $stable(cnt_q));

    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && run_en && cnt_q == CNT_MAX) |=> (cnt_q == '0));
endmodule

// File: rtl/pmt_status.sv
// Module: pmt_status
// Sticky status bit set by a top-bit change and cleared by a strobe. A set
// on the same edge as a clear wins. Drives the gated interrupt line.
// Assumes a synchronous active-low reset.
module pmt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    input  logic irq_en,
    output logic sts,
    output logic irq
);
    logic sts_q;

    // Status register: set has priority over clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sts_q <= 1'b0;
        else if (set_evt)
            sts_q <= 1'b1;
        else if (clr_req)
            sts_q <= 1'b0;
    end

    // Interrupt is the status gated by the enable.
    assign irq = sts_q & irq_en;
    assign sts = sts_q;

    a_r5_set_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> sts_q);

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> !sts_q);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && !clr_req) |=> sts_q);
endmodule

// File: rtl/freerun_pm_timer.sv
// Module: freerun_pm_timer (top)
// Free-running wrap-around timer whose top-bit changes raise a sticky
// status and a gated interrupt. The tick enable comes from outside; run_en
// stays high in low-power states.
// Assumes CNT_W >= 2 and a synchronous active-low reset.
module freerun_pm_timer #(
    parameter int unsigned CNT_W = pm_timer_pkg::PMT_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run_en,
    input  logic             irq_en,
    input  logic             sts_clr,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             sts
);
    logic top_flip;

    initial begin
        if (CNT_W < pm_timer_pkg::PMT_MIN_WIDTH)
            $error("freerun_pm_timer: CNT_W below minimum");
    end

    // Counter datapath.
    pmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .run_en   (run_en),
        .cnt      (count),
        .top_flip (top_flip)
    );

    // Status and interrupt.
    pmt_status u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (top_flip),
        .clr_req (sts_clr),
        .irq_en  (irq_en),
        .sts     (sts),
        .irq     (irq)
    );

    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !sts));

    a_r5_top_change: assert property (@(posedge clk) disable iff (!rst_n)
        (count[CNT_W-1] != $past(count[CNT_W-1])) |-> sts);
endmodule

// File: tb/test_freerun_pm_timer.sv
// Directed bench for freerun_pm_timer built with a narrow counter.
module test_freerun_pm_timer;
    localparam int unsigned W = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         run_en = 1'b0;
    logic         irq_en = 1'b0;
    logic         sts_clr = 1'b0;
    logic [W-1:0] count;
    logic         irq;
    logic         sts;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] exp_cnt = '0;
    logic         exp_sts = 1'b0;

    always #2.5 clk = ~clk;

    freerun_pm_timer #(.CNT_W(W)) i_freerun_pm_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
        .irq_en(irq_en), .sts_clr(sts_clr), .count(count), .irq(irq), .sts(sts)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // One clock with the given inputs; the model follows the requirements.
    task automatic step(input logic te, input logic re, input logic clr);
        logic [W-1:0] old;
        tick_en = te; run_en = re; sts_clr = clr;
        @(posedge clk);
        old = exp_cnt;
        if (te && re) exp_cnt = exp_cnt + 1'b1;
        if (old[W-1] != exp_cnt[W-1]) exp_sts = 1'b1;
        else if (clr) exp_sts = 1'b0;
        @(negedge clk);
        tick_en = 1'b0; sts_clr = 1'b0;
    endtask

    task automatic advance_to(input logic [W-1:0] target);
        while (exp_cnt != target) step(1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        exp_cnt = '0; exp_sts = 1'b0;
        chk("R1 count", count, 0);
        chk("R1 sts", sts, 0);
        irq_en = 1'b1; #1;
        chk("R1 irq", irq, 0);
        irq_en = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_count();
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0);
        chk("R2 count after 10", count, exp_cnt);
        chk("R2 count value", count, 10);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0);
        chk("R3 no tick", count, 10);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
        chk("R3 run off", count, 10);
        step(1'b1, 1'b1, 1'b0);
        chk("R2 resume", count, 11);
    endtask

    task automatic t_rise();
        advance_to(W'(31));
        chk("R5 no flag before rise", sts, 0);
        step(1'b1, 1'b1, 1'b0);
        chk("R5 count at rise", count, 32);
        chk("R5 flag on rise", sts, 1);
        irq_en = 1'b0; #1;
        chk("R8 irq gated off", irq, 0);
        irq_en = 1'b1; #1;
        chk("R8 irq enabled", irq, 1);
    endtask

    task automatic t_sticky();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0);
        chk("R7 sticky", sts, 1);
        step(1'b0, 1'b0, 1'b1);
        chk("R6 cleared", sts, 0);
        #1 chk("R8 irq follows clear", irq, 0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0);
        chk("R7 stays clear", sts, 0);
    endtask

    task automatic t_wrap();
        advance_to(W'(63));
        chk("R5 no flag before fall", sts, 0);
        step(1'b1, 1'b1, 1'b0);
        chk("R4 wrap to zero", count, 0);
        chk("R5 flag on fall", sts, 1);
        step(1'b1, 1'b1, 1'b0);
        chk("R4 after wrap", count, 1);
    endtask

    task automatic t_collide();
        step(1'b0, 1'b1, 1'b1);
        chk("R6 clear before collide", sts, 0);
        advance_to(W'(31));
        step(1'b1, 1'b1, 1'b1);
        chk("R6 set wins over clear", sts, 1);
        chk("R6 count at collide", count, 32);
        step(1'b0, 1'b1, 1'b1);
        chk("R6 clear later", sts, exp_sts);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_count();
        t_hold();
        t_rise();
        t_sticky();
        t_wrap();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule